// File: doc/BRIEF.md
# Spare Overhead Bit Validator with Interrupt Queue

This block sits after the superframe deframer of a 2B1Q-style subscriber line receiver. Once per superframe it takes the spare overhead bits from the M4 and M5/M6 positions, the received far-end block error bit and the result of the local CRC compare. Each spare bit passes through its own persistence filter. The filtered bits go into two receive registers. The block decides which events need the attention of the system.

Events go into a short queue. Each entry holds a source tag and a snapshot of the matching receive register. Two saturating error counters record CRC mismatches and far-end block errors. Each counter raises a queue entry when it reaches a programmable threshold. All detection and counting keeps running while an interrupt enable is clear; only the queue entry is suppressed. A small write port sets the configuration and the thresholds and issues clear commands. The system drains the queue through a pop strobe.

Top module: `ovh_bit_validator`

## Requirements
- R1: After reset the configuration reads 0x1E: mode field bits[1:0]=2 (confirm once), CRC interrupt enable bit2=1, count interrupt enable bit3=1, far-end error interrupt enable bit4=1. The receive registers, the counters, the queue and the overflow flag are all zero or empty.
- R2: In mode 0, every superframe strobe copies the received bits straight into both receive registers. It also queues one M4 entry (tag 0) and one M5/M6 entry (tag 1). An M4 entry carries the 3 M4 bits in data[2:0]. An M5/M6 entry carries data[3:0]=spare bits, data[4]=received far-end bit and data[5]=near-end flag, which is 1 unless the CRC compare failed.
- R3: In mode 1, a bit that differs from its register is accepted at the first strobe. An entry is queued only for a register in which a bit changed.
- R4: In modes 2 and 3, a new value must be seen on 2 or 3 consecutive strobes before the block accepts it. A strobe that brings the current register value, or a different candidate, restarts the count.
- R5: Each bit has its own candidate and count, so bits of one register can be accepted at different strobes.
- R6: A strobe with a CRC mismatch always increments counter 1. When the enable in bit2 is set, the strobe also queues an M5/M6 entry with data[5]=0.
- R7: A strobe whose far-end bit is 0 always increments counter 2. When the enable in bit4 is set, the strobe also queues an M5/M6 entry.
- R8: When bit3 is set, a counter whose increment makes it equal to its nonzero threshold (address 1 for counter 1, address 2 for counter 2) queues a tag 2 entry. That entry has data[0] set for counter 1 and data[1] set for counter 2. The entry fires once per crossing.
- R9: Counters saturate at all-ones and are readable at any time. Writing address 3 with bit0 clears counter 1 and with bit1 clears counter 2.
- R10: The queue holds 4 entries. Within one strobe the entries go in the order M4, M5/M6, count. A push into a full queue is dropped and sets a sticky overflow flag, which a write of address 3 with bit2 clears.
- R11: A pop in the same cycle as a strobe frees its slot before that strobe's entries are pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_strobe | input | 1 | One-cycle pulse per received superframe |
| m4_bits | input | W4 | Spare bits from M4 positions |
| m56_bits | input | W56 | Spare bits from M5/M6 positions |
| febe_bit | input | 1 | Received far-end block error bit (0 = error) |
| crc_err | input | 1 | Local CRC differs from received CRC |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | 0 config, 1 threshold 1, 2 threshold 2, 3 command |
| cfg_wdata | input | 8 | Write data |
| irq_pop | input | 1 | Remove head queue entry |
| cfg_q | output | 8 | Configuration register |
| m4_q | output | W4 | Validated M4 receive register |
| m56_q | output | W56 | Validated M5/M6 receive register |
| err_cnt1 | output | CW | CRC mismatch counter |
| err_cnt2 | output | CW | Far-end block error counter |
| irq_valid | output | 1 | Queue not empty |
| irq_tag | output | 2 | Head entry source: 0 M4, 1 M5/M6, 2 count |
| irq_data | output | W56+2 | Head entry snapshot |
| irq_ovf | output | 1 | Sticky queue overflow flag |

## Verification
One superframe strobe can produce an M4 change, a CRC mismatch entry and a threshold crossing together. Two collisions matter here: the strobe that produces all three at once, and a strobe that lands in the same cycle as a pop from a full queue. The bench provokes the first with a single strobe and judges it by the drain order and by which entry is lost to overflow. It provokes the second by raising the pop and the strobe on the same edge, and judges it by whether exactly the oldest entry leaves and exactly one new entry fits in.

// File: rtl/ovh_bit_validator.sv
module ovh_bit_validator #(
  parameter int W4    = 3,
  parameter int W56   = 4,
  parameter int CW    = 8,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sf_strobe,
  input  logic [W4-1:0]   m4_bits,
  input  logic [W56-1:0]  m56_bits,
  input  logic            febe_bit,
  input  logic            crc_err,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_addr,
  input  logic [7:0]      cfg_wdata,
  input  logic            irq_pop,
  output logic [7:0]      cfg_q,
  output logic [W4-1:0]   m4_q,
  output logic [W56-1:0]  m56_q,
  output logic [CW-1:0]   err_cnt1,
  output logic [CW-1:0]   err_cnt2,
  output logic            irq_valid,
  output logic [1:0]      irq_tag,
  output logic [W56+1:0]  irq_data,
  output logic            irq_ovf
);
  localparam int NB = W4 + W56;
  localparam int SW = W56 + 2;
  localparam int PW = $clog2(DEPTH);
  localparam int NP = 3;

  logic [1:0] mode;
  logic crc_ie, cnt_ie, febe_ie;
  assign mode    = cfg_q[1:0];
  assign crc_ie  = cfg_q[2];
  assign cnt_ie  = cfg_q[3];
  assign febe_ie = cfg_q[4];

  logic cmd, clr1, clr2, clr_ovf;
  assign cmd     = cfg_we && cfg_addr == 2'd3;
  assign clr1    = cmd && cfg_wdata[0];
  assign clr2    = cmd && cfg_wdata[1];
  assign clr_ovf = cmd && cfg_wdata[2];

  logic [CW-1:0] thr1, thr2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= 8'h1E;
      thr1  <= '0;
      thr2  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: cfg_q <= cfg_wdata;
        2'd1: thr1  <= CW'(cfg_wdata);
        2'd2: thr2  <= CW'(cfg_wdata);
        default: ;
      endcase
    end
  end

  logic [NB-1:0] rx_all, val_q, val_n;
  assign rx_all = {m56_bits, m4_bits};

  for (genvar i = 0; i < NB; i++) begin : g_bit
    logic q, cand, nq, ncand;
    logic [1:0] seen, nseen, s;
    always_comb begin
      nq = q; ncand = cand; nseen = seen; s = 2'd0;
      if (mode == 2'd0) begin
        nq = rx_all[i]; ncand = rx_all[i]; nseen = 2'd0;
      end else if (rx_all[i] == q) begin
        ncand = rx_all[i]; nseen = 2'd0;
      end else begin
        s = (rx_all[i] == cand && seen != 2'd0) ? seen + 2'd1 : 2'd1;
        if (s >= mode) begin
          nq = rx_all[i]; ncand = rx_all[i]; nseen = 2'd0;
        end else begin
          ncand = rx_all[i]; nseen = s;
        end
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= 1'b0; cand <= 1'b0; seen <= 2'd0;
      end else if (sf_strobe) begin
        q <= nq; cand <= ncand; seen <= nseen;
      end
    end
    assign val_q[i] = q;
    assign val_n[i] = nq;
  end

  assign m4_q  = val_q[W4-1:0];
  assign m56_q = val_q[NB-1:W4];

  logic crc_ev, febe_ev, ev_m4, ev_m56;
  assign crc_ev  = sf_strobe && crc_err;
  assign febe_ev = sf_strobe && !febe_bit;
  assign ev_m4   = sf_strobe && (mode == 2'd0 || val_n[W4-1:0] != val_q[W4-1:0]);
  assign ev_m56  = (sf_strobe && (mode == 2'd0 || val_n[NB-1:W4] != val_q[NB-1:W4]))
                 || (crc_ie && crc_ev) || (febe_ie && febe_ev);

  logic [CW-1:0] c1_inc, c2_inc;
  logic hit1, hit2, ev_cnt;
  assign c1_inc = err_cnt1 + CW'(1);
  assign c2_inc = err_cnt2 + CW'(1);
  assign hit1   = crc_ev && !clr1 && err_cnt1 != '1 && thr1 != '0 && c1_inc == thr1;
  assign hit2   = febe_ev && !clr2 && err_cnt2 != '1 && thr2 != '0 && c2_inc == thr2;
  assign ev_cnt = cnt_ie && (hit1 || hit2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_cnt1 <= '0;
      err_cnt2 <= '0;
    end else begin
      if (clr1) err_cnt1 <= '0;
      else if (crc_ev && err_cnt1 != '1) err_cnt1 <= c1_inc;
      if (clr2) err_cnt2 <= '0;
      else if (febe_ev && err_cnt2 != '1) err_cnt2 <= c2_inc;
    end
  end

  logic [NP-1:0] push_v;
  logic [1:0]    push_tag [NP];
  logic [SW-1:0] push_dat [NP];
  assign push_v      = {ev_cnt, ev_m56, ev_m4};
  assign push_tag[0] = 2'd0;
  assign push_tag[1] = 2'd1;
  assign push_tag[2] = 2'd2;
  assign push_dat[0] = SW'(val_n[W4-1:0]);
  assign push_dat[1] = {!crc_err, febe_bit, val_n[NB-1:W4]};
  assign push_dat[2] = SW'({hit2, hit1});

  logic [1:0]    tag_q [DEPTH];
  logic [SW-1:0] dat_q [DEPTH];
  logic [1:0]    tag_n [DEPTH];
  logic [SW-1:0] dat_n [DEPTH];
  logic [PW-1:0] rd_q, rd_n;
  logic [PW:0]   cnt_q, cnt_n;
  logic          ovf_n;

  always_comb begin
    tag_n = tag_q; dat_n = dat_q;
    rd_n = rd_q; cnt_n = cnt_q; ovf_n = irq_ovf && !clr_ovf;
    if (irq_pop && cnt_q != '0) begin
      rd_n  = rd_q + PW'(1);
      cnt_n = cnt_q - (PW+1)'(1);
    end
    for (int k = 0; k < NP; k++) begin
      if (push_v[k]) begin
        if (cnt_n < (PW+1)'(DEPTH)) begin
          tag_n[PW'(rd_n + PW'(cnt_n))] = push_tag[k];
          dat_n[PW'(rd_n + PW'(cnt_n))] = push_dat[k];
          cnt_n = cnt_n + (PW+1)'(1);
        end else begin
          ovf_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= '0;
      cnt_q   <= '0;
      irq_ovf <= 1'b0;
      for (int d = 0; d < DEPTH; d++) begin
        tag_q[d] <= '0;
        dat_q[d] <= '0;
      end
    end else begin
      rd_q    <= rd_n;
      cnt_q   <= cnt_n;
      irq_ovf <= ovf_n;
      tag_q   <= tag_n;
      dat_q   <= dat_n;
    end
  end

  assign irq_valid = cnt_q != '0;
  assign irq_tag   = tag_q[rd_q];
  assign irq_data  = dat_q[rd_q];

  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (PW+1)'(DEPTH));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_ovf) && !$past(clr_ovf)) |-> irq_ovf);

  // R9
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_cnt1) == '1 && !$past(clr1)) |-> err_cnt1 == '1);

  // R3
  m4_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sf_strobe) |-> $stable(m4_q));

  // R11
  pop_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_pop) && $past(irq_valid) && !$past(sf_strobe))
      |-> cnt_q == $past(cnt_q) - (PW+1)'(1));
endmodule

// File: tb/test_ovh_bit_validator.sv
module test_ovh_bit_validator;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sf_strobe = 0, febe_bit = 1, crc_err = 0, cfg_we = 0, irq_pop = 0;
  logic [2:0] m4_bits = '0;
  logic [3:0] m56_bits = '0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_q, err_cnt1, err_cnt2;
  logic [2:0] m4_q;
  logic [3:0] m56_q;
  logic irq_valid, irq_ovf;
  logic [1:0] irq_tag;
  logic [5:0] irq_data;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  ovh_bit_validator i_ovh_bit_validator (
    .clk, .rst_n, .sf_strobe, .m4_bits, .m56_bits, .febe_bit, .crc_err,
    .cfg_we, .cfg_addr, .cfg_wdata, .irq_pop, .cfg_q, .m4_q, .m56_q,
    .err_cnt1, .err_cnt2, .irq_valid, .irq_tag, .irq_data, .irq_ovf);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic sf(input logic [2:0] a, input logic [3:0] b, input logic fb,
                    input logic ce, input logic pop);
    @(negedge clk);
    m4_bits = a; m56_bits = b; febe_bit = fb; crc_err = ce; sf_strobe = 1; irq_pop = pop;
    @(negedge clk);
    sf_strobe = 0; irq_pop = 0; febe_bit = 1; crc_err = 0;
  endtask

  task automatic take(input string req, input int tag, input int dat);
    eq({req, " valid"}, irq_valid, 1);
    eq({req, " tag"}, irq_tag, tag);
    eq({req, " data"}, irq_data, dat);
    @(negedge clk); irq_pop = 1;
    @(negedge clk); irq_pop = 0;
  endtask

  task automatic t_reset;
    eq("R1 cfg", cfg_q, 8'h1E);
    eq("R1 empty", irq_valid, 0);
    eq("R1 cnt1", err_cnt1, 0);
    eq("R1 cnt2", err_cnt2, 0);
    eq("R1 ovf", irq_ovf, 0);
    eq("R1 m4", m4_q, 0);
    sf(3'd1, 4'd0, 1, 0, 0);
    eq("R1 mode2 first", m4_q, 0);
    eq("R1 no entry", irq_valid, 0);
    sf(3'd1, 4'd0, 1, 0, 0);
    eq("R1 mode2 second", m4_q, 1);
    take("R1", 0, 1);
  endtask

  task automatic t_mode0;
    wr(0, 8'h00);
    sf(3'd5, 4'd3, 1, 0, 0);
    eq("R2 m4", m4_q, 5);
    eq("R2 m56", m56_q, 3);
    take("R2 m4", 0, 5);
    take("R2 m56", 1, 6'h33);
    sf(3'd5, 4'd3, 1, 0, 0);
    take("R2 repeat m4", 0, 5);
    take("R2 repeat m56", 1, 6'h33);
    eq("R2 empty", irq_valid, 0);
  endtask

  task automatic t_mode1;
    wr(0, 8'h01);
    sf(3'd5, 4'd3, 1, 0, 0);
    eq("R3 unchanged no entry", irq_valid, 0);
    sf(3'd4, 4'd3, 1, 0, 0);
    eq("R3 m4", m4_q, 4);
    take("R3", 0, 4);
    eq("R3 only m4", irq_valid, 0);
  endtask

  task automatic t_mode3;
    wr(0, 8'h03);
    sf(3'd7, 4'd3, 1, 0, 0);
    sf(3'd7, 4'd3, 1, 0, 0);
    eq("R4 two seen", m4_q, 4);
    eq("R4 no entry", irq_valid, 0);
    sf(3'd7, 4'd3, 1, 0, 0);
    eq("R4 three seen", m4_q, 7);
    take("R4", 0, 7);
    sf(3'd0, 4'd3, 1, 0, 0);
    sf(3'd7, 4'd3, 1, 0, 0);
    sf(3'd0, 4'd3, 1, 0, 0);
    sf(3'd0, 4'd3, 1, 0, 0);
    eq("R4 restart", m4_q, 7);
    sf(3'd0, 4'd3, 1, 0, 0);
    eq("R4 after restart", m4_q, 0);
    take("R4 restart", 0, 0);
  endtask

  task automatic t_indep;
    wr(0, 8'h02);
    sf(3'd1, 4'd3, 1, 0, 0);
    sf(3'd3, 4'd3, 1, 0, 0);
    eq("R5 bit0 only", m4_q, 1);
    take("R5 a", 0, 1);
    sf(3'd3, 4'd3, 1, 0, 0);
    eq("R5 bit1 later", m4_q, 3);
    take("R5 b", 0, 3);
  endtask

  task automatic t_crc_febe;
    wr(0, 8'h05);
    sf(3'd3, 4'd3, 1, 1, 0);
    take("R6 enabled", 1, 6'h13);
    eq("R6 cnt", err_cnt1, 1);
    wr(0, 8'h01);
    sf(3'd3, 4'd3, 1, 1, 0);
    eq("R6 masked", irq_valid, 0);
    eq("R6 counted", err_cnt1, 2);
    wr(0, 8'h11);
    sf(3'd3, 4'd3, 0, 0, 0);
    take("R7 enabled", 1, 6'h23);
    eq("R7 cnt", err_cnt2, 1);
    wr(0, 8'h01);
    sf(3'd3, 4'd3, 0, 0, 0);
    eq("R7 masked", irq_valid, 0);
    eq("R7 counted", err_cnt2, 2);
    wr(3, 8'h03);
    eq("R9 clear1", err_cnt1, 0);
    eq("R9 clear2", err_cnt2, 0);
  endtask

  task automatic t_thresh;
    wr(1, 8'd2);
    wr(0, 8'h09);
    sf(3'd3, 4'd3, 1, 1, 0);
    eq("R8 below", irq_valid, 0);
    sf(3'd3, 4'd3, 1, 1, 0);
    take("R8 reach", 2, 1);
    sf(3'd3, 4'd3, 1, 1, 0);
    eq("R8 once", irq_valid, 0);
    eq("R8 cnt", err_cnt1, 3);
    wr(0, 8'h01);
    for (int i = 0; i < 260; i++) sf(3'd3, 4'd3, 1, 1, 0);
    eq("R9 saturate", err_cnt1, 255);
    wr(3, 8'h01);
    eq("R9 cleared", err_cnt1, 0);
  endtask

  task automatic t_order;
    wr(1, 8'd1);
    wr(0, 8'h0D);
    sf(3'd2, 4'd3, 1, 1, 0);
    sf(3'd3, 4'd3, 1, 1, 0);
    eq("R10 ovf", irq_ovf, 1);
    take("R10 first", 0, 2);
    take("R10 second", 1, 6'h13);
    take("R10 third", 2, 1);
    take("R10 fourth", 0, 3);
    eq("R10 drained", irq_valid, 0);
    eq("R10 sticky", irq_ovf, 1);
    wr(3, 8'h05);
    eq("R10 ovf clear", irq_ovf, 0);
  endtask

  task automatic t_same_cycle;
    wr(0, 8'h00);
    sf(3'd1, 4'd1, 1, 0, 0);
    sf(3'd2, 4'd2, 1, 0, 0);
    sf(3'd4, 4'd4, 1, 0, 1);
    eq("R11 ovf", irq_ovf, 1);
    take("R11 a", 1, 6'h31);
    take("R11 b", 0, 2);
    take("R11 c", 1, 6'h32);
    take("R11 d", 0, 4);
    eq("R11 empty", irq_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_mode1();
    t_mode3();
    t_indep();
    t_crc_febe();
    t_thresh();
    t_order();
    t_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule